// File: doc/BRIEF.md
# Phase-Shifted Carrier PWM Generator

This block produces the switching commands for every H-bridge cell stacked in one phase of a cascaded multilevel converter. A single up/down phase counter defines a triangular carrier. Each cell sees its own copy of that carrier, advanced by an even fraction of the carrier cycle. Because the carriers are spread evenly, their harmonic groups cancel when the cell voltages add in series.

A signed reference sample is taken once per carrier cycle and compared against every cell's carrier. Each cell gets two leg commands. Leg A is the positive leg and follows the reference. Leg B is the negative leg and follows the inverted reference. The cell output level is A minus B, so the cell can produce +1, 0 or -1. With N cells the phase can produce 2N+1 levels.

A reference whose magnitude exceeds the carrier peak is allowed. Such overmodulation holds the affected legs at a constant value. A per-cell bypass input forces a removed cell into its zero state, so the rest of the phase keeps running.

Top module: `pscpwm`

## Requirements
- R1: While reset is asserted, and in the first output sample after it, every leg command is low.
- R2: The carrier cycle lasts 2P clocks, where P is the `period` input (P ≥ 1). `sample_stb` pulses once per cycle, so consecutive pulses are 2P clocks apart. A new `period` value is adopted only when the running cycle ends: after a change just past a pulse, the next gap is P_old+P_new and the gaps after that are 2P_new.
- R3: `ref_in` is captured at the clock edge where `sample_stb` is high and is held unchanged until the next such edge. The outputs from the clock after capture through the next capture all use that value.
- R4: Carrier position t runs 0..2P-1. Its triangle height is h = t for t < P and h = 2P-t otherwise, and the carrier value is c = 2h-P. Leg A of a cell is high exactly when the held reference is strictly greater than c.
- R5: Leg B of a cell is high exactly when the negated held reference is strictly greater than c.
- R6: Cell k (k = 0..N-1) runs floor(2P·k/N) carrier positions ahead of cell 0.
- R7: A held reference above P keeps every leg A high and every leg B low. A held reference below -P keeps every leg A low and every leg B high.
- R8: When bypass bit k is 1, both leg commands of cell k are low from the next clock on. The other cells are unaffected.
- R9: While the held reference is zero or positive, no cell shows leg B high with leg A low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period | input | CNT_W | Carrier half-cycle length P in clocks (≥ 1) |
| ref_in | input | REF_W | Signed reference sample, two's complement |
| bypass | input | N_CELLS | Per-cell removal mask, bit k = cell k |
| sample_stb | output | 1 | High in the cycle whose closing edge captures `ref_in` |
| leg_a | output | N_CELLS | Positive-leg command per cell, bit k = cell k |
| leg_b | output | N_CELLS | Negative-leg command per cell, bit k = cell k |

## Verification
The hardest property to reach from the ports is the phase spacing between cells. Every cell has the same duty cycle, so the phase offset only shows up in when the edges occur. The stimulus holds the reference at zero, which gives each cell exactly one rising edge per carrier cycle. It records one complete cycle aligned to `sample_stb` and compares the rising-edge positions of each cell with cell 0. This is done for a period that N divides evenly and for one it does not, so the floor rounding is exercised. The overmodulation, bypass and period-change cases use the same strobe-aligned capture window.

// File: rtl/pscpwm.sv
module pscpwm #(
  parameter int N_CELLS = 6,
  parameter int REF_W   = 12,
  parameter int CNT_W   = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CNT_W-1:0]        period,
  input  logic signed [REF_W-1:0] ref_in,
  input  logic [N_CELLS-1:0]      bypass,
  output logic                    sample_stb,
  output logic [N_CELLS-1:0]      leg_a,
  output logic [N_CELLS-1:0]      leg_b
);
  localparam int PH_W  = CNT_W + 1;
  localparam int CMP_W = ((REF_W > PH_W + 1) ? REF_W : PH_W + 1) + 1;
  localparam int OFF_W = PH_W + $clog2(N_CELLS) + 1;

  logic [CNT_W-1:0]        per_q;
  logic [PH_W-1:0]         ph;
  logic [PH_W-1:0]         span;
  logic                    wrap;
  logic signed [REF_W-1:0] ref_q;
  logic signed [CMP_W-1:0] ref_x, ref_n;
  logic [N_CELLS-1:0]      a_nx, b_nx;

  assign span       = {per_q, 1'b0};
  assign wrap       = ({1'b0, ph} + 1'b1) >= {1'b0, span};
  assign sample_stb = (ph == {1'b0, per_q});
  assign ref_x      = {{(CMP_W-REF_W){ref_q[REF_W-1]}}, ref_q};
  assign ref_n      = -ref_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= '0;
      per_q <= '0;
      ref_q <= '0;
    end else begin
      if (wrap) begin
        ph    <= '0;
        per_q <= period;
      end else begin
        ph <= ph + 1'b1;
      end
      if (sample_stb) ref_q <= ref_in;
    end
  end

  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    logic [OFF_W-1:0]        prod;
    logic [PH_W-1:0]         off;
    logic [PH_W:0]           sum;
    logic [PH_W-1:0]         pos;
    logic [PH_W-1:0]         tri_h;
    logic signed [CMP_W-1:0] car;

    assign prod  = OFF_W'(span) * OFF_W'(k);
    assign off   = PH_W'(prod / OFF_W'(N_CELLS));
    assign sum   = {1'b0, ph} + {1'b0, off};
    assign pos   = (sum >= {1'b0, span}) ? PH_W'(sum - {1'b0, span}) : PH_W'(sum);
    assign tri_h = (pos < {1'b0, per_q}) ? pos : span - pos;
    assign car   = $signed(CMP_W'({tri_h, 1'b0})) - $signed(CMP_W'(per_q));
    assign a_nx[k] = ref_x > car;
    assign b_nx[k] = ref_n > car;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      leg_a <= '0;
      leg_b <= '0;
    end else begin
      leg_a <= a_nx & ~bypass;
      leg_b <= b_nx & ~bypass;
    end
  end
endmodule

// File: rtl/pscpwm_chk.sv
module pscpwm_chk #(
  parameter int N_CELLS = 6,
  parameter int REF_W   = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_CELLS-1:0]      bypass,
  input logic                    sample_stb,
  input logic [N_CELLS-1:0]      leg_a,
  input logic [N_CELLS-1:0]      leg_b,
  input logic signed [REF_W-1:0] ref_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (leg_a == '0 && leg_b == '0));

  // R8
  bypass_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass != '0) |=> (((leg_a | leg_b) & $past(bypass)) == '0));

  // R2
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  // R3
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(ref_q));

  // R9
  sign_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_q >= 0) |=> ((leg_b & ~leg_a) == '0));
endmodule

bind pscpwm pscpwm_chk #(.N_CELLS(N_CELLS), .REF_W(REF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bypass(bypass), .sample_stb(sample_stb),
  .leg_a(leg_a), .leg_b(leg_b), .ref_q(ref_q)
);

// File: tb/pscpwm_tb.sv
module pscpwm_tb;
  localparam int N  = 6;
  localparam int RW = 12;
  localparam int CW = 11;
  localparam int MAXW = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] period = CW'(60);
  logic signed [RW-1:0] ref_in = '0;
  logic [N-1:0] bypass = '0;
  logic sample_stb;
  logic [N-1:0] leg_a, leg_b;

  logic [N-1:0] sa [MAXW];
  logic [N-1:0] sb [MAXW];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pscpwm #(.N_CELLS(N), .REF_W(RW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .period(period), .ref_in(ref_in),
    .bypass(bypass), .sample_stb(sample_stb), .leg_a(leg_a), .leg_b(leg_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_cnt(input int r, input int p);
    int n = 0;
    for (int t = 0; t < 2*p; t++) begin
      int h = (t < p) ? t : 2*p - t;
      if (r > 2*h - p) n++;
    end
    return n;
  endfunction

  task automatic capture(input int p);
    do @(negedge clk); while (!sample_stb);
    @(posedge clk);
    @(posedge clk);
    for (int i = 0; i < 2*p; i++) begin
      @(negedge clk);
      sa[i] = leg_a;
      sb[i] = leg_b;
    end
  endtask

  task automatic gap(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sample_stb);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk(leg_a == '0, "R1 leg_a", int'(leg_a), 0);
    chk(leg_b == '0, "R1 leg_b", int'(leg_b), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(leg_a == '0 && leg_b == '0, "R1 first sample", int'({leg_a, leg_b}), 0);
  endtask

  task automatic test_period();
    int g;
    do @(negedge clk); while (!sample_stb);
    gap(g);
    chk(g == 120, "R2 steady gap", g, 120);
    period = CW'(40);
    gap(g);
    chk(g == 100, "R2 transition gap", g, 100);
    gap(g);
    chk(g == 80, "R2 new gap", g, 80);
    period = CW'(60);
    gap(g);
    gap(g);
    chk(g == 120, "R2 restored gap", g, 120);
  endtask

  task automatic test_duty(input int r, input int p);
    int ca, cb, ea, eb, bad;
    ref_in = RW'(r);
    capture(p);
    ea = exp_cnt(r, p);
    eb = exp_cnt(-r, p);
    for (int k = 0; k < N; k++) begin
      ca = 0; cb = 0;
      for (int i = 0; i < 2*p; i++) begin
        ca += int'(sa[i][k]);
        cb += int'(sb[i][k]);
      end
      chk(ca == ea, $sformatf("R4 R3 cell %0d ref %0d", k, r), ca, ea);
      chk(cb == eb, $sformatf("R5 cell %0d ref %0d", k, r), cb, eb);
    end
    if (r >= 0) begin
      bad = 0;
      for (int i = 0; i < 2*p; i++) bad += $countones(sb[i] & ~sa[i]);
      chk(bad == 0, $sformatf("R9 ref %0d", r), bad, 0);
    end
  endtask

  task automatic test_phase(input int p);
    int rise [N];
    bit prev;
    int got, want;
    period = CW'(p);
    ref_in = '0;
    repeat (2) do @(negedge clk); while (!sample_stb);
    capture(p);
    for (int k = 0; k < N; k++) begin
      rise[k] = -1;
      for (int i = 0; i < 2*p; i++) begin
        prev = (i == 0) ? sa[2*p-1][k] : sa[i-1][k];
        if (sa[i][k] && !prev) rise[k] = i;
      end
    end
    for (int k = 1; k < N; k++) begin
      got = (rise[0] - rise[k] + 2*p) % (2*p);
      want = (2*p*k) / N;
      chk(got == want, $sformatf("R6 cell %0d period %0d", k, p), got, want);
    end
    period = CW'(60);
    repeat (2) do @(negedge clk); while (!sample_stb);
  endtask

  task automatic test_overmod();
    int ca, cb;
    ref_in = RW'(65);
    capture(60);
    ca = 0; cb = 0;
    for (int i = 0; i < 120; i++) begin
      ca += $countones(sa[i]);
      cb += $countones(sb[i]);
    end
    chk(ca == 120*N, "R7 positive leg A", ca, 120*N);
    chk(cb == 0, "R7 positive leg B", cb, 0);
    ref_in = -RW'(65);
    capture(60);
    ca = 0; cb = 0;
    for (int i = 0; i < 120; i++) begin
      ca += $countones(sa[i]);
      cb += $countones(sb[i]);
    end
    chk(ca == 0, "R7 negative leg A", ca, 0);
    chk(cb == 120*N, "R7 negative leg B", cb, 120*N);
  endtask

  task automatic test_bypass();
    int ca, cb, ea;
    logic [N-1:0] m = N'(6'b010010);
    bypass = m;
    ref_in = RW'(25);
    @(negedge clk);
    chk(((leg_a | leg_b) & m) == '0, "R8 next clock", int'((leg_a | leg_b) & m), 0);
    capture(60);
    ea = exp_cnt(25, 60);
    for (int k = 0; k < N; k++) begin
      ca = 0; cb = 0;
      for (int i = 0; i < 120; i++) begin
        ca += int'(sa[i][k]);
        cb += int'(sb[i][k]);
      end
      if (m[k]) chk(ca + cb == 0, $sformatf("R8 removed cell %0d", k), ca + cb, 0);
      else      chk(ca == ea, $sformatf("R8 kept cell %0d", k), ca, ea);
    end
    bypass = '0;
  endtask

  initial begin
    test_reset();
    test_period();
    test_duty(0, 60);
    test_duty(25, 60);
    test_duty(-37, 60);
    test_duty(60, 60);
    test_duty(-60, 60);
    test_phase(60);
    test_phase(50);
    test_overmod();
    test_bypass();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule